// File: doc/BRIEF.md
# Indexed GPIO Register Controller

This peripheral puts twenty general-purpose pins behind a byte-wide I/O bus. The pins are split into three ports: two full ports of eight bits (A and B) and one narrow port of four bits (C). Each port has a direction register and a data register. Neither register is directly addressed.

The host reaches a port register in two steps. First it writes an index byte to the pointer address. It then reads or writes the window address, and that access goes to the register the pointer names. The pointer keeps its value, so the host can repeat window accesses without rewriting it.

On the pin side, every bit has an output value, an output-enable and an input level. The input level is passed through a two-stage synchronizer before the host can read it. A data-register read returns a mix of two sources: the output latch for output-mode bits and the synchronized pin level for input-mode bits.

Top module: `idx_gpio_ctrl`

## Requirements
- R1: After reset, every `pin_oe` and `pin_out` bit is 0, and a read at address 22h returns 00h.
- R2: A write at address 22h loads the index pointer with `bus_wdata`. A later read at 22h returns that value.
- R3: Accesses at 23h leave the index pointer unchanged, so successive window accesses all reach the same register.
- R4: The direction registers sit at index A5h (port A), A4h (port B) and A3h (port C). A 1 bit makes that pin an output (`pin_oe` high). Pin bits 7:0 belong to port A, bits 15:8 to port B and bits 19:16 to port C.
- R5: The data registers sit at index A9h (A), A8h (B) and A7h (C). A byte written there appears on that port's `pin_out` bits on the cycle after the write.
- R6: A data-register read returns the output latch for bits whose direction bit is 1, and the synchronized pin level for bits whose direction bit is 0.
- R7: An input pin change is not visible one clock edge after it occurs. It becomes visible after the second rising edge.
- R8: Bits 7:4 of port C's direction and data registers read as 0, and writes to those bits have no effect.
- R9: A read at 23h with an index that maps to no register returns FFh. A write there changes no output and no register.
- R10: `bus_rdata` is 00h when `bus_rd` is low and when reading any address other than 22h or 23h. Writes to other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | I/O address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is valid combinationally while it is high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| pin_out | output | 20 | Output values (A at 7:0, B at 15:8, C at 19:16) |
| pin_oe | output | 20 | Per-pin output enable |
| pin_in | input | 20 | Pin levels, asynchronous |

## Verification
A seeded random stream mixes five kinds of operation: pointer writes, window writes, window reads, pointer reads and pin changes. The pointer values are drawn mostly from the sparse band A3h–A9h, so the unmapped hole at A6h and the narrow port C are hit often. Random bytes outside that band also probe unmapped behaviour, and comparing window reads against a bench model separates direction, latch and pin sources bit by bit. Directed cases pin down three things: the exact edge at which a pin change becomes readable, the masking of port C's upper nibble, and the rule that an unmapped write leaves every pin unchanged.

// File: rtl/idx_gpio_pkg.sv
// Shared constants for the indexed GPIO controller: port geometry and index map.
package idx_gpio_pkg;
    localparam int NPORT = 3;
    localparam int NPIN  = 20;
    // Width and pin offset of each port (A, B, C).
    localparam int PORT_W   [NPORT] = '{8, 8, 4};
    localparam int PORT_OFS [NPORT] = '{0, 8, 16};
    // Port p has its direction register at MODE_BASE - p and its data register at DATA_BASE - p.
    localparam logic [7:0] MODE_BASE = 8'hA5;
    localparam logic [7:0] DATA_BASE = 8'hA9;
endpackage

// File: rtl/idx_gpio_sync.sv
// Two-flop synchronizer for asynchronous pin inputs.
// Assumes: pins may change at any time; the result is stable after two edges.
module idx_gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Shift the pin levels through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/idx_gpio_port.sv
// One GPIO port: a direction register, an output latch and an input synchronizer.
// Assumes: W <= 8; readback is zero-extended to a byte.
module idx_gpio_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_we,
    input  logic         data_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] mode_q,
    output logic [W-1:0] dat_q,
    output logic [7:0]   mode_rd,
    output logic [7:0]   data_rd
);
    logic [W-1:0] pin_sync;

    idx_gpio_sync #(.W(W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    // Update the direction register and output latch on their write enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            dat_q  <= '0;
        end else begin
            if (mode_we) mode_q <= wdata;
            if (data_we) dat_q  <= wdata;
        end
    end

    // Zero-extend both readback values; data bits come from the latch or the pin, by direction.
    always_comb begin
        mode_rd = '0;
        data_rd = '0;
        mode_rd[W-1:0] = mode_q;
        data_rd[W-1:0] = (dat_q & mode_q) | (pin_sync & ~mode_q);
    end
endmodule

// File: rtl/idx_gpio_ctrl.sv
// Indexed GPIO controller top. An index pointer at IDX_ADDR selects a port
// register; the window at DATA_ADDR reads or writes it.
// Assumes: single-cycle write strobes; read data is used combinationally.
module idx_gpio_ctrl
    import idx_gpio_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] IDX_ADDR  = ADDR_W'('h22),
    parameter logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'('h23)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    input  logic [NPIN-1:0]   pin_in
);
    logic [7:0]       idx_q;
    logic             idx_we;
    logic             win_we;
    logic [NPORT-1:0] hit_mode;
    logic [NPORT-1:0] hit_data;
    logic [7:0]       mode_rd [NPORT];
    logic [7:0]       data_rd [NPORT];
    logic [7:0]       win_rd;

    assign idx_we = bus_wr && (bus_addr == IDX_ADDR);
    assign win_we = bus_wr && (bus_addr == DATA_ADDR);

    // Hold the index pointer; only a write at the pointer address changes it.
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= 8'h00;
        else if (idx_we) idx_q <= bus_wdata;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam int W = PORT_W[p];
        localparam int O = PORT_OFS[p];
        logic [W-1:0] mode_q;
        logic [W-1:0] dat_q;

        assign hit_mode[p] = (idx_q == MODE_BASE - 8'(p));
        assign hit_data[p] = (idx_q == DATA_BASE - 8'(p));

        idx_gpio_port #(.W(W)) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode_we (win_we && hit_mode[p]),
            .data_we (win_we && hit_data[p]),
            .wdata   (bus_wdata[W-1:0]),
            .pin_in  (pin_in[O +: W]),
            .mode_q  (mode_q),
            .dat_q   (dat_q),
            .mode_rd (mode_rd[p]),
            .data_rd (data_rd[p])
        );

        assign pin_oe[O +: W]  = mode_q;
        assign pin_out[O +: W] = dat_q;
    end

    // Select the window readback from the register the pointer names; FFh when unmapped.
    always_comb begin
        win_rd = 8'hFF;
        for (int p = 0; p < NPORT; p++) begin
            if (hit_mode[p]) win_rd = mode_rd[p];
            if (hit_data[p]) win_rd = data_rd[p];
        end
    end

    // Drive the read bus only during a read of one of the two mapped addresses.
    always_comb begin
        bus_rdata = 8'h00;
        if (bus_rd) begin
            if (bus_addr == IDX_ADDR)       bus_rdata = idx_q;
            else if (bus_addr == DATA_ADDR) bus_rdata = win_rd;
        end
    end
endmodule

// File: rtl/idx_gpio_chk.sv
// Protocol checker for idx_gpio_ctrl, attached with bind.
// Assumes: the same address parameters as the top.
module idx_gpio_chk #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] IDX_ADDR  = ADDR_W'('h22),
    parameter logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'('h23),
    parameter int                NPIN      = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic [NPIN-1:0]   pin_out,
    input logic [NPIN-1:0]   pin_oe,
    input logic [7:0]        idx_q
);
    logic win_wr;
    logic idx_wr;
    logic unmapped;
    assign win_wr   = bus_wr && (bus_addr == DATA_ADDR);
    assign idx_wr   = bus_wr && (bus_addr == IDX_ADDR);
    assign unmapped = (idx_q < 8'hA3) || (idx_q > 8'hA9) || (idx_q == 8'hA6);

    AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (idx_q == $past(bus_wdata)));                              // R2
    AST_IDX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_wr |=> $stable(idx_q));                                          // R3
    AST_IDX_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == IDX_ADDR) |-> (bus_rdata == idx_q));           // R2
    AST_MODE_A: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && idx_q == 8'hA5) |=> (pin_oe[7:0] == $past(bus_wdata)));   // R4
    AST_DATA_B: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && idx_q == 8'hA8) |=> (pin_out[15:8] == $past(bus_wdata))); // R5
    AST_PORTC_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == DATA_ADDR && (idx_q == 8'hA3 || idx_q == 8'hA7))
        |-> (bus_rdata[7:4] == 4'h0));                                        // R8
    AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == DATA_ADDR && unmapped) |-> (bus_rdata == 8'hFF)); // R9
    AST_PINS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_wr || unmapped) |=> ($stable(pin_oe) && $stable(pin_out)));     // R9
    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == 8'h00));                                    // R10
endmodule

bind idx_gpio_ctrl idx_gpio_chk #(
    .ADDR_W    (ADDR_W),
    .IDX_ADDR  (IDX_ADDR),
    .DATA_ADDR (DATA_ADDR),
    .NPIN      (idx_gpio_pkg::NPIN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .idx_q     (idx_q)
);

// File: tb/test_idx_gpio_ctrl.sv
// Self-checking bench: seeded random operations plus directed corners,
// compared against a bench model built from the requirements.
module test_idx_gpio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [19:0] pin_out;
    logic [19:0] pin_oe;
    logic [19:0] pin_in = 20'h0;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Bench model state.
    logic [7:0]  m_idx = 8'h00;
    logic [7:0]  m_mode [3] = '{8'h00, 8'h00, 8'h00};
    logic [7:0]  m_dat  [3] = '{8'h00, 8'h00, 8'h00};
    logic [19:0] m_s1 = 20'h0;
    logic [19:0] m_s2 = 20'h0;
    localparam logic [7:0] MASK [3] = '{8'hFF, 8'hFF, 8'h0F};
    localparam int OFS [3] = '{0, 8, 16};

    always #5 clk = ~clk;

    idx_gpio_ctrl i_idx_gpio_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in)
    );

    // Model of the two-stage input synchronizer (R7).
    always @(posedge clk) begin
        if (!rst_n) begin m_s1 <= '0; m_s2 <= '0; end
        else begin m_s1 <= pin_in; m_s2 <= m_s1; end
    end

    function automatic logic [7:0] port_pins(input logic [19:0] v, input int p);
        return 8'(v >> OFS[p]) & MASK[p];
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        logic [7:0] r;
        if (a == 8'h22) return m_idx;
        if (a != 8'h23) return 8'h00;
        r = 8'hFF;
        for (int p = 0; p < 3; p++) begin
            if (m_idx == 8'hA5 - 8'(p)) r = m_mode[p];
            if (m_idx == 8'hA9 - 8'(p))
                r = (m_dat[p] & m_mode[p]) | (port_pins(m_s2, p) & ~m_mode[p]);
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%05h expected=%05h", tag, act, exp);
        end
    endtask

    task automatic check_pins(input string tag);
        check({tag, " pin_oe"}, pin_oe, {m_mode[2][3:0], m_mode[1], m_mode[0]});
        check({tag, " pin_out"}, pin_out, {m_dat[2][3:0], m_dat[1], m_dat[0]});
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        if (a == 8'h22) m_idx = d;
        else if (a == 8'h23)
            for (int p = 0; p < 3; p++) begin
                if (m_idx == 8'hA5 - 8'(p)) m_mode[p] = d & MASK[p];
                if (m_idx == 8'hA9 - 8'(p)) m_dat[p]  = d & MASK[p];
            end
    endtask

    // Read and compare against an explicit expected value.
    task automatic read_exp(input string tag, input logic [7:0] a, input logic [7:0] e);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 check(tag, 20'(bus_rdata), 20'(e));
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    // Read and compare against the model.
    task automatic read_model(input string tag, input logic [7:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 check(tag, 20'(bus_rdata), 20'(exp_read(a)));
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1CE5));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        check_pins("R1 reset");
        read_exp("R1 reset index", 8'h22, 8'h00);
        check("R1 idle rdata R10", 20'(bus_rdata), 20'h0);

        // R2/R4/R5: set port A as output, drive a value
        bus_write(8'h22, 8'hA5);
        read_exp("R2 index readback", 8'h22, 8'hA5);
        bus_write(8'h23, 8'hFF);
        check_pins("R4 port A output");
        bus_write(8'h22, 8'hA9);
        bus_write(8'h23, 8'h3C);
        check_pins("R5 data A");
        // R3: pointer persists over window accesses
        bus_write(8'h23, 8'hC3);
        read_exp("R3 repeated window", 8'h23, 8'hC3);
        read_exp("R3 index kept", 8'h22, 8'hA9);

        // R8: port C upper nibble
        bus_write(8'h22, 8'hA3);
        bus_write(8'h23, 8'hFF);
        read_exp("R8 port C mode", 8'h23, 8'h0F);
        check_pins("R8 port C pins");

        // R7: sync latency on port B (input mode, index A8h)
        bus_write(8'h22, 8'hA8);
        @(negedge clk) pin_in[15:8] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk) pin_in[15:8] = 8'h96;
        read_exp("R7 one edge old", 8'h23, 8'h00);
        read_exp("R7 two edges new", 8'h23, 8'h96);

        // R6: mixed direction on port B
        bus_write(8'h22, 8'hA4);
        bus_write(8'h23, 8'hF0);
        bus_write(8'h22, 8'hA8);
        bus_write(8'h23, 8'hA5);
        read_exp("R6 mixed B", 8'h23, 8'hA6);

        // R9: unmapped index
        bus_write(8'h22, 8'hA6);
        read_exp("R9 unmapped read", 8'h23, 8'hFF);
        bus_write(8'h23, 8'h55);
        check_pins("R9 unmapped write");
        bus_write(8'h22, 8'h10);
        read_exp("R9 unmapped low", 8'h23, 8'hFF);

        // R10: other addresses
        bus_write(8'h40, 8'hAB);
        read_exp("R10 other address read", 8'h40, 8'h00);
        read_exp("R10 pointer unchanged", 8'h22, 8'h10);
        check_pins("R10 other write");

        // Random mix against the model (R2..R9)
        for (int i = 0; i < 3000; i++) begin
            int op;
            op = int'($urandom % 6);
            case (op)
                0: bus_write(8'h22, ($urandom % 8 == 0) ? 8'($urandom) : 8'hA3 + 8'($urandom % 7));
                1: begin bus_write(8'h23, 8'($urandom)); check_pins("R4 R5 R9 random write"); end
                2, 3: read_model("R6 R8 R9 random window read", 8'h23);
                4: read_model("R2 R3 random index read", 8'h22);
                default: begin @(negedge clk) pin_in = 20'($urandom); end
            endcase
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule